// File: doc/BRIEF.md
# Synchronous Burst Data RAM

This block is a synthesizable behavioural model of the data store of a secondary cache. Each word is 72 bits wide, split into eight byte lanes of nine bits (eight data bits plus a parity bit). All transfers are synchronous to one clock. An active-low address strobe captures an external address and opens a burst. An active-low count-enable then steps a 2-bit burst counter through the four words of a cache line, or holds the counter still to insert wait states.

The burst order is chosen per beat by a mode input. Linear order adds the beat count to the starting word offset and wraps within the line. Interleaved order XORs the starting offset with the beat count. A cycle writes when any byte enable is low and reads otherwise. Read data is registered once and shows on the output in the cycle after the edge that accepted the read. The output enable only gates that data.

Top module: `sync_burst_ram`

## Requirements
- R1: When `standby_i` is high at a rising edge, no read or write takes place, `rvalid_o` is low in the following cycle, and the burst address state is held, so a later advance continues from where the burst stopped.
- R2: When `standby_i` is low and `addr_strobe_ni` is low at a rising edge, `addr_i` is captured. Bits [1:0] are the starting word offset and the upper bits select the line. That beat accesses `addr_i` itself.
- R3: An active beat is a write when any bit of `byte_we_ni` is low and a read otherwise. After a write beat, `rvalid_o` is low and `rdata_o` is zero whatever `out_en_ni` is.
- R4: With `addr_strobe_ni` high and `cnt_en_ni` low, the beat count increments by one modulo 4 and the beat accesses the next burst address in the same line.
- R5: With `addr_strobe_ni` and `cnt_en_ni` both high, the count is kept and the beat accesses the same address as the previous beat (wait state).
- R6: With `burst_ilv_i` low, the word offset is (start + count) mod 4. For example, start 1 gives 1,2,3,0.
- R7: With `burst_ilv_i` high, the word offset is start XOR count. For example, start 2 gives 2,3,0,1. The mode input is sampled on every beat.
- R8: Lane k is `wdata_i[9k+8:9k]`. A write beat stores lane k only when `byte_we_ni[k]` is 0. All other lanes keep their old contents.
- R9: A read beat accepted at edge N shows the stored word on `rdata_o`, with `rvalid_o` high, from just after edge N until edge N+1, provided `out_en_ni` is low.
- R10: While `out_en_ni` is high, `rdata_o` is zero and `rvalid_o` is low.
- R11: After reset (`rst_ni` low), `rvalid_o` is low, `rdata_o` is zero, and the line, start offset and count are zero. An advance with no prior strobe therefore reads address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Deselect; high blocks the access |
| addr_strobe_ni | input | 1 | Load external address and start a burst, active low |
| cnt_en_ni | input | 1 | Advance the burst counter, active low |
| byte_we_ni | input | 8 | Per-lane write enables, active low |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_ni | input | 1 | Read data output enable, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 72 | Write data, eight 9-bit lanes |
| rdata_o | output | 72 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data on rdata_o is valid |

## Verification
The bench targets the wrap of a linear burst from a non-zero start and an interleaved burst from offset 2. A counter that does not wrap, or that uses the wrong order, would read the wrong line word. A wait state in the middle of a burst must repeat the same word; a design that kept counting would skip a word. A deselect in the middle of a burst must leave the count alone; a design that cleared it would restart the burst. Partial-lane writes must leave the other lanes intact, and a read issued on a write cycle must be ruled out. A design that wrote every lane, or that drove data after a write, would be caught.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } beat_op_e;

  // word offset inside a line for a given beat
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/sburst_addr_ctrl.sv
module sburst_addr_ctrl
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              addr_strobe_ni,
  input  logic              cnt_en_ni,
  input  logic              any_we_i,
  input  logic              burst_ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output beat_op_e          op_o
);
  localparam int LINE_W = ADDR_W - 2;

  logic [LINE_W-1:0] line_q, line_n;
  logic [1:0]        start_q, start_n;
  logic [1:0]        cnt_q, cnt_n;

  always_comb begin
    line_n  = line_q;
    start_n = start_q;
    cnt_n   = cnt_q;
    op_o    = OP_IDLE;
    if (!standby_i) begin
      op_o = any_we_i ? OP_WRITE : OP_READ;
      if (!addr_strobe_ni) begin
        line_n  = addr_i[ADDR_W-1:2];
        start_n = addr_i[1:0];
        cnt_n   = 2'd0;
      end else if (!cnt_en_ni) begin
        cnt_n = cnt_q + 2'd1;
      end
    end
    acc_addr_o = {line_n, burst_offset(start_n, cnt_n, burst_ilv_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      line_q  <= line_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
    end
  end

  assert_hold_on_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> ($stable(cnt_q) && $stable(line_q) && $stable(start_q)));

  assert_load_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !addr_strobe_ni) |=>
      (cnt_q == 2'd0 && line_q == $past(addr_i[ADDR_W-1:2]) && start_q == $past(addr_i[1:0])));

  assert_advance_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && addr_strobe_ni && !cnt_en_ni) |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_suspend_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && addr_strobe_ni && cnt_en_ni) |=> ($stable(cnt_q) && $stable(line_q)));

endmodule

// File: rtl/sburst_lane.sv
module sburst_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
    if (rd_en_i) rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    standby_i,
  input  logic                    addr_strobe_ni,
  input  logic                    cnt_en_ni,
  input  logic [LANES-1:0]        byte_we_ni,
  input  logic                    burst_ilv_i,
  input  logic                    out_en_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DATA_W = LANES * LANE_W;

  beat_op_e          op;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] word_q;
  logic              rd_valid_q;

  sburst_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .standby_i      (standby_i),
    .addr_strobe_ni (addr_strobe_ni),
    .cnt_en_ni      (cnt_en_ni),
    .any_we_i       (~&byte_we_ni),
    .burst_ilv_i    (burst_ilv_i),
    .addr_i         (addr_i),
    .acc_addr_o     (acc_addr),
    .op_o           (op)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sburst_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .wr_en_i (op == OP_WRITE && !byte_we_ni[k]),
      .rd_en_i (op == OP_READ),
      .addr_i  (acc_addr),
      .wdata_i (wdata_i[k*LANE_W +: LANE_W]),
      .rdata_o (word_q[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= (op == OP_READ);
  end

  assign rvalid_o = rd_valid_q && !out_en_ni;
  assign rdata_o  = rvalid_o ? word_q : '0;

  assert_deselect_no_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !rd_valid_q);

  assert_write_no_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !(&byte_we_ni)) |=> (!rvalid_o && rdata_o == '0));

  assert_read_flows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && (&byte_we_ni)) |=> rd_valid_q);

endmodule

// File: tb/tb_sync_burst_ram.sv
`timescale 1ns/1ps
module tb_sync_burst_ram;
  localparam int AW = 8;
  localparam int DW = 72;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic standby_i = 1'b1, addr_strobe_ni = 1'b1, cnt_en_ni = 1'b1;
  logic [7:0] byte_we_ni = 8'hff;
  logic burst_ilv_i = 1'b0, out_en_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rvalid_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [256];
  logic [5:0] m_line;
  logic [1:0] m_start, m_cnt;
  logic [AW-1:0] m_acc;

  sync_burst_ram dut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cycles++;

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] w;
    for (int k = 0; k < 8; k++) w[k*9 +: 9] = 9'((a * 13 + k * 41 + 7) ^ (k << 5));
    return w;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_line = '0; m_start = '0; m_cnt = '0;
    #3;
    chk1("R11 rvalid after reset", rvalid_o, 1'b0);
    chk("R11 rdata after reset", rdata_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one beat: drive at negedge, predict, sample 2ns after the rising edge
  task automatic cyc(input logic sb, input logic as_n, input logic ce_n,
                     input logic [7:0] we_n, input logic ilv, input logic oe_n,
                     input logic [AW-1:0] ad, input logic [DW-1:0] wd, input string tag);
    logic ev;
    logic [DW-1:0] ed;
    standby_i = sb; addr_strobe_ni = as_n; cnt_en_ni = ce_n; byte_we_ni = we_n;
    burst_ilv_i = ilv; out_en_ni = oe_n; addr_i = ad; wdata_i = wd;
    ev = 1'b0; ed = '0;
    if (!sb) begin
      if (!as_n) begin
        m_line = ad[AW-1:2]; m_start = ad[1:0]; m_cnt = 2'd0;
      end else if (!ce_n) begin
        m_cnt = m_cnt + 2'd1;
      end
      m_acc = {m_line, (ilv ? (m_start ^ m_cnt) : (m_start + m_cnt))};
      if (we_n != 8'hff) begin
        for (int k = 0; k < 8; k++)
          if (!we_n[k]) m_mem[m_acc][k*9 +: 9] = wd[k*9 +: 9];
      end else if (!oe_n) begin
        ev = 1'b1; ed = m_mem[m_acc];
      end
    end
    @(posedge clk_i);
    #2;
    chk1(tag, rvalid_o, ev);
    chk(tag, rdata_o, ed);
    @(negedge clk_i);
  endtask

  initial begin
    while (!done && cycles < 150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_w;
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R11: advance with no strobe after reset; first fill address 1 so it can be read
    cyc(0, 0, 1, 8'h00, 0, 0, 8'h01, pat(1), "R3 fill addr1");
    do_reset();
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R11 advance after reset");
    chk("R11 reads address 1", rdata_o, pat(1));

    // prefill with single-beat writes (R2, R3)
    for (int a = 0; a < 256; a++)
      cyc(0, 0, 1, 8'h00, 0, (a % 2 == 0), 8'(a), pat(a), "R3 write beat");

    // R6 linear from offset 1 in line 5
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h15, '0, "R2 load read");
    chk("R6 beat0", rdata_o, pat(8'h15));
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R4 advance");
    chk("R6 beat1", rdata_o, pat(8'h16));
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R4 advance");
    chk("R6 beat2", rdata_o, pat(8'h17));
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R4 advance");
    chk("R6 wrap beat3", rdata_o, pat(8'h14));

    // R7 interleaved from offset 2 in line 9
    cyc(0, 0, 1, 8'hff, 1, 0, 8'h26, '0, "R2 load read");
    chk("R7 beat0", rdata_o, pat(8'h26));
    cyc(0, 1, 0, 8'hff, 1, 0, '0, '0, "R4 advance");
    chk("R7 beat1", rdata_o, pat(8'h27));
    cyc(0, 1, 0, 8'hff, 1, 0, '0, '0, "R4 advance");
    chk("R7 beat2", rdata_o, pat(8'h24));
    cyc(0, 1, 0, 8'hff, 1, 0, '0, '0, "R4 advance");
    chk("R7 beat3", rdata_o, pat(8'h25));

    // R5 wait state
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h30, '0, "R2 load read");
    cyc(0, 1, 1, 8'hff, 0, 0, '0, '0, "R5 suspend");
    chk("R5 same word", rdata_o, pat(8'h30));
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R4 advance");
    chk("R5 then next word", rdata_o, pat(8'h31));

    // R1 deselect mid-burst keeps the count
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h40, '0, "R2 load read");
    cyc(1, 1, 0, 8'h00, 0, 0, '0, {DW{1'b1}}, "R1 deselect");
    chk1("R1 no read data", rvalid_o, 1'b0);
    cyc(0, 1, 0, 8'hff, 0, 0, '0, '0, "R1 resume");
    chk("R1 resumes at 0x41", rdata_o, pat(8'h41));
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h42, '0, "R1 write ignored");
    chk("R1 deselected write ignored", rdata_o, pat(8'h42));

    // R8 partial lane write
    cyc(0, 0, 1, 8'b1111_0110, 0, 0, 8'h50, {DW{1'b1}}, "R8 partial write");
    exp_w = pat(8'h50);
    exp_w[0 +: 9] = 9'h1ff;
    exp_w[27 +: 9] = 9'h1ff;
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h50, '0, "R8 read back");
    chk("R8 lanes merged", rdata_o, exp_w);

    // R10 output enable high, R3 write with output enabled
    cyc(0, 0, 1, 8'hff, 0, 1, 8'h60, '0, "R10 oe high");
    chk1("R10 rvalid low", rvalid_o, 1'b0);
    cyc(0, 0, 1, 8'h7f, 0, 0, 8'h61, pat(8'h61), "R3 write hides data");
    chk("R3 rdata zero on write", rdata_o, '0);
    cyc(0, 0, 1, 8'hff, 0, 0, 8'h60, '0, "R9 read flows");
    chk("R9 data next cycle", rdata_o, pat(8'h60));

    // constrained random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic sb, asn, cen, ilv, oen;
      logic [7:0] we;
      string tg;
      sb  = ($urandom_range(0, 9) == 0);
      asn = ($urandom_range(0, 4) != 0);
      cen = ($urandom_range(0, 2) == 0);
      ilv = 1'($urandom_range(0, 1));
      oen = ($urandom_range(0, 5) == 0);
      we  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'hff;
      if (sb) tg = "R1 random";
      else if (we != 8'hff) tg = "R8 random";
      else if (oen) tg = "R10 random";
      else if (!asn) tg = "R2 random";
      else if (cen) tg = "R5 random";
      else tg = ilv ? "R7 random" : "R6 random";
      cyc(sb, asn, cen, we, ilv, oen, 8'($urandom), {8'($urandom), 32'($urandom), 32'($urandom)}, tg);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule